// File: doc/BRIEF.md
# Translation Unit Control and Fault Register Block

This block is the software-visible register file of a small address-translation unit that sits in front of a video codec. It runs on a simple single-cycle register bus. A write takes effect at the clock edge on which it is presented. Read data is combinational in the same cycle.

It holds the settings the translation walker needs: a global enable, the base address of the translation-table array, an out-of-bound check enable and a cache invalidate-all trigger. It drives those settings to the walker as plain outputs. In the other direction it takes fault events from the walker, each carrying cause bits and the faulting address. It keeps the causes in a sticky status register and captures the first faulting address. It raises an interrupt while a cause is pending and reporting is enabled.

Software brings the unit up with four writes in order: the table base, the out-of-bound enable, the exception enable and then the control enable. It invalidates the walker cache by setting the flush bit and clearing it straight away. No completion flag is polled, so the flush request leaves the block as a single self-contained pulse.

Top module: `xlatCtrlRegs`

## Requirements
- R1: After reset, every register reads 0, and `xlatEnable`, `tableBase`, `oobCheckEn`, `flushPulse` and `irq` are all 0.
- R2: Offset 0x388 is the control register. Bit 0 drives `xlatEnable` and reads back. Writing 0 disables translation. The other bits read 0.
- R3: Offset 0x38C holds the 32-bit table base. It reads back in full and drives `tableBase`.
- R4: Offset 0x1AC is the config register. Only bit 28 is stored. It drives `oobCheckEn`, and every other bit reads 0.
- R5: Offset 0x184 stores bit 4 as the flush bit, which reads back. A write that takes the flush bit from 0 to 1 makes `flushPulse` high for exactly the one cycle after that write. Writing 1 while the bit is already 1 gives no pulse.
- R6: A fault event (`faultValid` high) sets the status bits named in `faultCause`. Bits [2:0] of offset 0x384 hold these causes, and they accumulate until cleared.
- R7: A write to offset 0x384 clears each status bit whose write-data bit is 0 and keeps each bit whose write-data bit is 1. Writing 0 therefore clears all causes.
- R8: `irq` is high exactly when the exception-enable bit is 1 and at least one status bit is set.
- R9: At offset 0x380 the meaning depends on direction. A write sets exception enable from data bit 0. A read returns the captured fault address, not the enable.
- R10: The fault address is captured only when a fault arrives while no cause is pending. It holds while causes remain pending. After a full clear, the next fault loads a new address.
- R11: Reads of any other offset return 0, and writes to any other offset change no register and no output.
- R12: The four-write bring-up sequence (base, config bit 28, exception enable, control) leaves translation enabled, out-of-bound checking on, the base driven and `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle |
| faultValid | input | 1 | Fault event from the walker |
| faultCause | input | 3 | Cause bits of the fault event |
| faultAddr | input | 32 | Faulting address |
| xlatEnable | output | 1 | Translation enable to the walker |
| tableBase | output | 32 | Translation-table array base |
| oobCheckEn | output | 1 | Out-of-bound checking enable |
| flushPulse | output | 1 | One-cycle invalidate-all request |
| irq | output | 1 | Fault interrupt |

## Verification
Register writes and fault events are captured on the edge at which they are presented. Their effects on read data, `xlatEnable`, `tableBase`, `oobCheckEn` and `irq` are therefore due by the next falling edge. Reads are combinational, so they are sampled a moment after the address is driven and before the following rising edge. `flushPulse` is registered. The bench expects it high at the falling edge right after the write that sets the bit, and low one cycle later. Every check is made on a falling edge, so no result depends on the order of processes at the rising edge.

// File: rtl/xlat_regs_pkg.sv
package xlat_regs_pkg;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int CAUSE_W = 3;

  localparam logic [ADDR_W-1:0] OFS_FLUSH = 12'h184;
  localparam logic [ADDR_W-1:0] OFS_CFG   = 12'h1AC;
  localparam logic [ADDR_W-1:0] OFS_EXC   = 12'h380;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h384;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h388;
  localparam logic [ADDR_W-1:0] OFS_BASE  = 12'h38C;

  localparam int FLUSH_BIT = 4;
  localparam int OOB_BIT   = 28;
  localparam int EN_BIT    = 0;

  typedef enum logic [2:0] {
    RD_NONE, RD_FLUSH, RD_CFG, RD_FADDR, RD_STAT, RD_CTRL, RD_BASE
  } rdSel_e;

  typedef struct packed {
    logic   wrFlush;
    logic   wrCfg;
    logic   wrExc;
    logic   wrStat;
    logic   wrCtrl;
    logic   wrBase;
    rdSel_e rdSel;
  } regStb_t;
endpackage

// File: rtl/xlatRegCtrl.sv
module xlatRegCtrl
  import xlat_regs_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busSel,
  input  logic          busWr,
  input  logic [AW-1:0] busAddr,
  output regStb_t       stb
);
  logic doWr;
  logic doRd;

  assign doWr = busSel & busWr;
  assign doRd = busSel & ~busWr;

  always_comb begin
    stb = '0;
    stb.rdSel = RD_NONE;
    unique case (busAddr)
      AW'(OFS_FLUSH): begin stb.wrFlush = doWr; if (doRd) stb.rdSel = RD_FLUSH; end
      AW'(OFS_CFG):   begin stb.wrCfg   = doWr; if (doRd) stb.rdSel = RD_CFG;   end
      AW'(OFS_EXC):   begin stb.wrExc   = doWr; if (doRd) stb.rdSel = RD_FADDR; end
      AW'(OFS_STAT):  begin stb.wrStat  = doWr; if (doRd) stb.rdSel = RD_STAT;  end
      AW'(OFS_CTRL):  begin stb.wrCtrl  = doWr; if (doRd) stb.rdSel = RD_CTRL;  end
      AW'(OFS_BASE):  begin stb.wrBase  = doWr; if (doRd) stb.rdSel = RD_BASE;  end
      default: ;
    endcase
  end

  AST_ONE_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrFlush, stb.wrCfg, stb.wrExc, stb.wrStat, stb.wrCtrl, stb.wrBase})); // R11
  AST_NO_READ_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr) |-> (stb.rdSel == RD_NONE)); // R9
endmodule

// File: rtl/xlatRegData.sv
module xlatRegData
  import xlat_regs_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CAUSE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  regStb_t       stb,
  input  logic [DW-1:0] busWdata,
  input  logic          faultValid,
  input  logic [CW-1:0] faultCause,
  input  logic [DW-1:0] faultAddr,
  output logic [DW-1:0] busRdata,
  output logic          xlatEn,
  output logic [DW-1:0] tableBase,
  output logic          oobEn,
  output logic          flushPulse,
  output logic          irq
);
  logic          excEnQ;
  logic          flushBitQ;
  logic [CW-1:0] statusQ;
  logic [CW-1:0] statusNext;
  logic [CW-1:0] keptStatus;
  logic [DW-1:0] faultAddrQ;
  logic          faultLoad;

  // Per-cause sticky bits: a fault sets the bit, and a status write keeps it only where the data bit is 1
  for (genvar i = 0; i < CW; i++) begin : g_cause
    assign keptStatus[i] = statusQ[i] & ~(stb.wrStat & ~busWdata[i]);
    assign statusNext[i] = keptStatus[i] | (faultValid & faultCause[i]);
  end

  assign faultLoad = faultValid && (|faultCause) && (keptStatus == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xlatEn     <= 1'b0;
      tableBase  <= '0;
      oobEn      <= 1'b0;
      excEnQ     <= 1'b0;
      flushBitQ  <= 1'b0;
      flushPulse <= 1'b0;
      statusQ    <= '0;
      faultAddrQ <= '0;
    end else begin
      if (stb.wrCtrl) xlatEn <= busWdata[EN_BIT];
      if (stb.wrBase) tableBase <= busWdata;
      if (stb.wrCfg) oobEn <= busWdata[OOB_BIT];
      if (stb.wrExc) excEnQ <= busWdata[EN_BIT];
      if (stb.wrFlush) flushBitQ <= busWdata[FLUSH_BIT];
      flushPulse <= stb.wrFlush & busWdata[FLUSH_BIT] & ~flushBitQ;
      statusQ <= statusNext;
      if (faultLoad) faultAddrQ <= faultAddr;
    end
  end

  assign irq = excEnQ & (|statusQ);

  always_comb begin
    busRdata = '0;
    unique case (stb.rdSel)
      RD_FLUSH: busRdata[FLUSH_BIT] = flushBitQ;
      RD_CFG:   busRdata[OOB_BIT]   = oobEn;
      RD_FADDR: busRdata            = faultAddrQ;
      RD_STAT:  busRdata[CW-1:0]    = statusQ;
      RD_CTRL:  busRdata[EN_BIT]    = xlatEn;
      RD_BASE:  busRdata            = tableBase;
      default:  busRdata            = '0;
    endcase
  end

  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    flushPulse |=> !flushPulse); // R5
  AST_FADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ((|statusQ) && !stb.wrStat) |=> $stable(faultAddrQ)); // R10
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ((|statusQ) && !stb.wrStat) |=> ((statusQ & $past(statusQ)) == $past(statusQ))); // R6
  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCtrl |=> (xlatEn == $past(busWdata[EN_BIT]))); // R2
endmodule

// File: rtl/xlatCtrlRegs.sv
module xlatCtrlRegs
  import xlat_regs_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int CW = CAUSE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busSel,
  input  logic          busWr,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  output logic [DW-1:0] busRdata,
  input  logic          faultValid,
  input  logic [CW-1:0] faultCause,
  input  logic [DW-1:0] faultAddr,
  output logic          xlatEnable,
  output logic [DW-1:0] tableBase,
  output logic          oobCheckEn,
  output logic          flushPulse,
  output logic          irq
);
  regStb_t stb;

  xlatRegCtrl #(.AW(AW)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .stb(stb)
  );

  xlatRegData #(.DW(DW), .CW(CW)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .faultValid(faultValid), .faultCause(faultCause), .faultAddr(faultAddr),
    .busRdata(busRdata), .xlatEn(xlatEnable), .tableBase(tableBase),
    .oobEn(oobCheckEn), .flushPulse(flushPulse), .irq(irq)
  );
endmodule

// File: tb/sim_xlatCtrlRegs.sv
module sim_xlatCtrlRegs;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        faultValid = 1'b0;
  logic [2:0]  faultCause = '0;
  logic [31:0] faultAddr = '0;
  logic        xlatEnable, oobCheckEn, flushPulse, irq;
  logic [31:0] tableBase;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  xlatCtrlRegs u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .faultValid(faultValid),
    .faultCause(faultCause), .faultAddr(faultAddr), .xlatEnable(xlatEnable),
    .tableBase(tableBase), .oobCheckEn(oobCheckEn), .flushPulse(flushPulse), .irq(irq)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [11:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  // write wd to addr, read addr back, expect exp
  localparam vec_t VECS [11] = '{
    '{4'd2,  12'h388, 32'h0000_0001, 32'h0000_0001},
    '{4'd2,  12'h388, 32'hFFFF_FFFF, 32'h0000_0001},
    '{4'd2,  12'h388, 32'h0000_0000, 32'h0000_0000},
    '{4'd3,  12'h38C, 32'h1234_5678, 32'h1234_5678},
    '{4'd3,  12'h38C, 32'hFFFF_FC00, 32'hFFFF_FC00},
    '{4'd4,  12'h1AC, 32'hFFFF_FFFF, 32'h1000_0000},
    '{4'd4,  12'h1AC, 32'h0000_0000, 32'h0000_0000},
    '{4'd5,  12'h184, 32'hFFFF_FFFF, 32'h0000_0010},
    '{4'd5,  12'h184, 32'h0000_0000, 32'h0000_0000},
    '{4'd7,  12'h384, 32'h0000_0007, 32'h0000_0000},
    '{4'd11, 12'h100, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic fault(input logic [2:0] c, input logic [31:0] a);
    @(negedge clk);
    faultValid = 1'b1; faultCause = c; faultAddr = a;
    @(negedge clk);
    faultValid = 1'b0; faultCause = '0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 xlatEnable", {31'b0, xlatEnable}, 32'h0);
    check("R1 tableBase", tableBase, 32'h0);
    check("R1 oob/flush/irq", {29'b0, oobCheckEn, flushPulse, irq}, 32'h0);
    busRead(12'h384, rd); check("R1 status", rd, 32'h0);
    busRead(12'h380, rd); check("R1 fault address", rd, 32'h0);

    // table walk: R2 R3 R4 R5 R7 R11
    foreach (VECS[i]) begin
      busWrite(VECS[i].addr, VECS[i].wd);
      busRead(VECS[i].addr, rd);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].exp);
    end

    // R12 and R3: bring-up sequence
    busWrite(12'h38C, 32'h0ABC_D000);
    busWrite(12'h1AC, 32'h1000_0000);
    busWrite(12'h380, 32'h1);
    busWrite(12'h388, 32'h1);
    check("R3 tableBase port", tableBase, 32'h0ABC_D000);
    check("R12 enable/oob/irq", {29'b0, xlatEnable, oobCheckEn, irq}, 32'h6);
    busRead(12'h380, rd); check("R9 read is fault address", rd, 32'h0);

    // R5: flush pulse
    busWrite(12'h184, 32'h10);
    check("R5 pulse after set", {31'b0, flushPulse}, 32'h1);
    @(negedge clk);
    check("R5 pulse one cycle", {31'b0, flushPulse}, 32'h0);
    busWrite(12'h184, 32'h10);
    check("R5 no pulse when already set", {31'b0, flushPulse}, 32'h0);
    busWrite(12'h184, 32'h0);
    busWrite(12'h184, 32'h10);
    check("R5 pulse after reclear", {31'b0, flushPulse}, 32'h1);
    busWrite(12'h184, 32'h0);

    // R6 R8 R10: faults
    fault(3'b001, 32'h1000_0040);
    busRead(12'h384, rd); check("R6 status first", rd, 32'h1);
    check("R8 irq raised", {31'b0, irq}, 32'h1);
    busRead(12'h380, rd); check("R10 first address", rd, 32'h1000_0040);
    fault(3'b100, 32'h2000_0000);
    busRead(12'h384, rd); check("R6 status accumulates", rd, 32'h5);
    busRead(12'h380, rd); check("R10 address held", rd, 32'h1000_0040);

    // R7: selective clear then full clear
    busWrite(12'h384, 32'h4);
    busRead(12'h384, rd); check("R7 partial clear", rd, 32'h4);
    busRead(12'h380, rd); check("R10 held while pending", rd, 32'h1000_0040);
    busWrite(12'h384, 32'h0);
    busRead(12'h384, rd); check("R7 full clear", rd, 32'h0);
    check("R8 irq drops", {31'b0, irq}, 32'h0);
    fault(3'b010, 32'h0000_3000);
    busRead(12'h380, rd); check("R10 new address after clear", rd, 32'h0000_3000);

    // R8 and R9: exception enable gates irq
    busWrite(12'h380, 32'h0);
    check("R8 irq gated off", {31'b0, irq}, 32'h0);
    busRead(12'h384, rd); check("R8 status kept while gated", rd, 32'h2);
    busRead(12'h380, rd); check("R9 write did not hit address", rd, 32'h0000_3000);
    busWrite(12'h380, 32'h1);
    check("R8 irq regated on", {31'b0, irq}, 32'h1);
    busWrite(12'h384, 32'h0);

    // R11: unmapped writes change nothing
    busWrite(12'h100, 32'hFFFF_FFFF);
    busWrite(12'h390, 32'h0);
    busWrite(12'h388 + 12'h1, 32'h0);
    check("R11 outputs unchanged", {28'b0, xlatEnable, oobCheckEn, flushPulse, irq}, 32'hC);
    check("R11 base unchanged", tableBase, 32'h0ABC_D000);
    busRead(12'h390, rd); check("R11 unmapped read", rd, 32'h0);
    busRead(12'h184, rd); check("R11 flush bit unchanged", rd, 32'h0);

    // R2: disable
    busWrite(12'h388, 32'h0);
    check("R2 disable", {31'b0, xlatEnable}, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule